// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers two groups of sixteen level-sensitive interrupt requests, called group A and group B. It samples each group into a pending register on every clock and qualifies each group with a per-pin enable mask. Every source that is both pending and enabled drives one of five processor interrupt lines. The line is chosen by a 3-bit route code held in one of four route registers. Only some pins have a programmable code. The other pins always drive line 0.

Software reaches the block through a 16-bit register port with two address windows, chosen by `reg_win_i`. Each window holds a pending view and a mask register. Window A also holds the four route registers. Reads are combinational. A write takes effect at the clock edge on which `reg_wr_i` is sampled high. The block has no state machine. Its only sequencing is the sampling register in front of the pending view and the register on the interrupt outputs.

Top module: `irq_router_top`

## Requirements
- R1: While reset is applied and after it is released, `irq_o` is 0 and both mask registers read 0. The route registers read 0x0040, 0x0000, 0x0002 and 0x0000.
- R2: Line k of `irq_o` is high exactly when at least one pin has its pending bit and its mask bit both 1 and its route equal to k. The line changes at the clock edge after the edge that updates the pending, mask or route state involved.
- R3: The group A mask is read/write at window A offset 0x0C. The group B mask is read/write at window B offset 0x06. All 16 bits of both masks are stored.
- R4: Offset 0x00 reads the group A pending value in window A and the group B pending value in window B. The pending value is the request input as sampled at the previous clock edge. Writes to offset 0x00 have no effect.
- R5: Each route register holds five 3-bit codes, at bits [2:0], [5:3], [8:6], [11:9] and [14:12]. Bit 15 always reads 0.
- R6: The group A pins map to route codes as follows. Pins 0, 1, 2, 3 and 8 take codes 0 to 4 of window A offset 0x04. Pins 9, 11 and 12 take the codes at bits [2:0], [8:6] and [11:9] of offset 0x06.
- R7: The group B pins map to route codes as follows. Pins 0, 1, 3, 4 and 5 take codes 0 to 4 of window A offset 0x1C. Pins 6 to 10 take codes 0 to 4 of offset 0x1E.
- R8: A route code written with a value of 5, 6 or 7 leaves that code unchanged. Legal codes in the same write are still stored.
- R9: Pins that have no route code always drive line 0. These are group A pins 4–7, 10 and 13–15, and group B pins 2 and 11–15.
- R10: The route defaults are line 1 for group A pin 2, line 2 for group B pin 0, and line 0 for every other pin.
- R11: Offsets that are not mapped read 0, and writes to them change no register. This covers odd offsets and offsets valid only in the other window.
- R12: Sources from group A and group B are ORed onto the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a_i | input | 16 | Group A level requests |
| req_b_i | input | 16 | Group B level requests |
| reg_win_i | input | 1 | Register window select: 0 = window A, 1 = window B |
| reg_addr_i | input | 5 | Byte offset within the window |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data |
| irq_o | output | 5 | Registered processor interrupt lines 0–4 |

## Verification
The hardest case to reach from the ports is a single route write that mixes illegal codes with legal ones. The bench loads a known route value, then writes one word that has out-of-range values in the first and last code positions, legal values in the middle, and bit 15 set. Reading the register back shows which codes were kept and which were stored. The unrouted pins and the defaulted pins only show their fixed routes when every mask bit is enabled and one request is raised at a time. The vector table walks every routable pin with non-default codes loaded, so a swapped field or pin position moves the result onto a different line.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int GRP_W     = 16;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int NUM_OUT   = 5;
    localparam int CODE_W    = 3;
    localparam int CODES_PER = 5;
    localparam int NUM_RTE   = 4;
    localparam int MAX_CODE  = NUM_OUT - 1;

    // window A offsets
    localparam logic [ADDR_W-1:0] OFF_PEND   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_RTE0   = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RTE1   = 5'h06;
    localparam logic [ADDR_W-1:0] OFF_MASK_A = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_RTE2   = 5'h1C;
    localparam logic [ADDR_W-1:0] OFF_RTE3   = 5'h1E;
    // window B offsets
    localparam logic [ADDR_W-1:0] OFF_MASK_B = 5'h06;

    typedef logic [CODE_W-1:0]            code_t;
    typedef code_t [CODES_PER-1:0]        rte_reg_t;
    typedef rte_reg_t [NUM_RTE-1:0]       rte_bank_t;
    typedef logic [GRP_W-1:0]             grp_vec_t;

    typedef struct packed {
        logic       has;
        logic [1:0] reg_idx;
        logic [2:0] slot;
    } pin_map_t;

    // Reset contents of the route bank: group A pin 2 -> line 1, group B pin 0 -> line 2
    function automatic rte_bank_t rte_reset();
        rte_bank_t b;
        b          = '0;
        b[0][2]    = code_t'(1);
        b[2][0]    = code_t'(2);
        return b;
    endfunction

    // Which route code (if any) steers a given pin
    function automatic pin_map_t map_pin(input logic grp_b, input int pin);
        pin_map_t m;
        m = '0;
        if (!grp_b) begin
            case (pin)
                0, 1, 2, 3: m = '{1'b1, 2'd0, 3'(pin)};
                8:          m = '{1'b1, 2'd0, 3'd4};
                9:          m = '{1'b1, 2'd1, 3'd0};
                11:         m = '{1'b1, 2'd1, 3'd2};
                12:         m = '{1'b1, 2'd1, 3'd3};
                default:    m = '0;
            endcase
        end else begin
            case (pin)
                0, 1:              m = '{1'b1, 2'd2, 3'(pin)};
                3, 4, 5:           m = '{1'b1, 2'd2, 3'(pin - 1)};
                6, 7, 8, 9, 10:    m = '{1'b1, 2'd3, 3'(pin - 6)};
                default:           m = '0;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/irt_regs.sv
module irt_regs
    import irt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  grp_vec_t          req_a_i,
    input  grp_vec_t          req_b_i,
    input  logic              reg_win_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output grp_vec_t          pend_a_o,
    output grp_vec_t          pend_b_o,
    output grp_vec_t          mask_a_o,
    output grp_vec_t          mask_b_o,
    output rte_bank_t         rte_o
);

    grp_vec_t  pend_a_q, pend_b_q, mask_a_q, mask_b_q;
    rte_bank_t rte_q, rte_d;
    logic      wr_mask_a, wr_mask_b;
    logic [NUM_RTE-1:0] wr_rte;

    // write decode
    always_comb begin
        wr_mask_a = reg_wr_i && !reg_win_i && (reg_addr_i == OFF_MASK_A);
        wr_mask_b = reg_wr_i &&  reg_win_i && (reg_addr_i == OFF_MASK_B);
        wr_rte[0] = reg_wr_i && !reg_win_i && (reg_addr_i == OFF_RTE0);
        wr_rte[1] = reg_wr_i && !reg_win_i && (reg_addr_i == OFF_RTE1);
        wr_rte[2] = reg_wr_i && !reg_win_i && (reg_addr_i == OFF_RTE2);
        wr_rte[3] = reg_wr_i && !reg_win_i && (reg_addr_i == OFF_RTE3);
    end

    // per-code write filter: illegal codes keep the old value
    always_comb begin
        rte_d = rte_q;
        for (int r = 0; r < NUM_RTE; r++) begin
            if (wr_rte[r]) begin
                for (int f = 0; f < CODES_PER; f++) begin
                    if (reg_wdata_i[f*CODE_W +: CODE_W] <= code_t'(MAX_CODE))
                        rte_d[r][f] = reg_wdata_i[f*CODE_W +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_a_q <= '0;
            pend_b_q <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
            rte_q    <= rte_reset();
        end else begin
            pend_a_q <= req_a_i;
            pend_b_q <= req_b_i;
            if (wr_mask_a) mask_a_q <= reg_wdata_i;
            if (wr_mask_b) mask_b_q <= reg_wdata_i;
            rte_q <= rte_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        if (!reg_win_i) begin
            case (reg_addr_i)
                OFF_PEND:   reg_rdata_o = pend_a_q;
                OFF_MASK_A: reg_rdata_o = mask_a_q;
                OFF_RTE0:   reg_rdata_o = {1'b0, rte_q[0]};
                OFF_RTE1:   reg_rdata_o = {1'b0, rte_q[1]};
                OFF_RTE2:   reg_rdata_o = {1'b0, rte_q[2]};
                OFF_RTE3:   reg_rdata_o = {1'b0, rte_q[3]};
                default:    reg_rdata_o = '0;
            endcase
        end else begin
            case (reg_addr_i)
                OFF_PEND:   reg_rdata_o = pend_b_q;
                OFF_MASK_B: reg_rdata_o = mask_b_q;
                default:    reg_rdata_o = '0;
            endcase
        end
    end

    assign pend_a_o = pend_a_q;
    assign pend_b_o = pend_b_q;
    assign mask_a_o = mask_a_q;
    assign mask_b_o = mask_b_q;
    assign rte_o    = rte_q;

    AST_MASK_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_a |=> $stable(mask_a_q)); // R3
    AST_MASK_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_b |=> $stable(mask_b_q)); // R11

    for (genvar r = 0; r < NUM_RTE; r++) begin : g_rte_chk
        for (genvar f = 0; f < CODES_PER; f++) begin : g_code_chk
            AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                rte_q[r][f] <= code_t'(MAX_CODE)); // R8
        end
        AST_RTE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_rte[r] |=> $stable(rte_q[r])); // R11
    end

endmodule

// File: rtl/irt_route.sv
module irt_route
    import irt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  grp_vec_t           pend_a_i,
    input  grp_vec_t           pend_b_i,
    input  grp_vec_t           mask_a_i,
    input  grp_vec_t           mask_b_i,
    input  rte_bank_t          rte_i,
    output logic [NUM_OUT-1:0] irq_o
);

    grp_vec_t           act_a, act_b;
    code_t              code_a [GRP_W];
    code_t              code_b [GRP_W];
    logic [NUM_OUT-1:0] hit, irq_q;
    logic               unused_rte_bits;

    assign act_a = pend_a_i & mask_a_i;
    assign act_b = pend_b_i & mask_b_i;

    // resolve each pin's line: a programmable code or the fixed line 0
    for (genvar i = 0; i < GRP_W; i++) begin : g_pin
        localparam pin_map_t MA = map_pin(1'b0, i);
        localparam pin_map_t MB = map_pin(1'b1, i);
        if (MA.has) begin : g_a_prog
            assign code_a[i] = rte_i[MA.reg_idx][MA.slot];
        end else begin : g_a_fixed
            assign code_a[i] = '0;
        end
        if (MB.has) begin : g_b_prog
            assign code_b[i] = rte_i[MB.reg_idx][MB.slot];
        end else begin : g_b_fixed
            assign code_b[i] = '0;
        end
    end

    // codes that no pin reads
    assign unused_rte_bits = ^{rte_i[1][1], rte_i[1][4]};

    always_comb begin
        hit = '0;
        for (int i = 0; i < GRP_W; i++) begin
            for (int k = 0; k < NUM_OUT; k++) begin
                if (act_a[i] && (code_a[i] == code_t'(k))) hit[k] = 1'b1;
                if (act_b[i] && (code_b[i] == code_t'(k))) hit[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= hit;
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q != '0) |-> ($past(mask_a_i | mask_b_i) != '0)); // R2
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q != '0) |-> ($past(pend_a_i | pend_b_i) != '0)); // R2
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_a | act_b) == '0) |=> (irq_q == '0)); // R12

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] req_a_i,
    input  logic [15:0] req_b_i,
    input  logic        reg_win_i,
    input  logic [4:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic [4:0]  irq_o
);

    grp_vec_t  pend_a, pend_b, mask_a, mask_b;
    rte_bank_t rte;

    irt_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_a_i     (req_a_i),
        .req_b_i     (req_b_i),
        .reg_win_i   (reg_win_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .pend_a_o    (pend_a),
        .pend_b_o    (pend_b),
        .mask_a_o    (mask_a),
        .mask_b_o    (mask_b),
        .rte_o       (rte)
    );

    irt_route i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_a_i (pend_a),
        .pend_b_i (pend_b),
        .mask_a_i (mask_a),
        .mask_b_i (mask_b),
        .rte_i    (rte),
        .irq_o    (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0)); // R1

endmodule

// File: tb/test_irq_router_top.sv
module test_irq_router_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_a = '0, req_b = '0;
    logic        win = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  irq;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_router_top i_irq_router_top (
        .clk(clk), .rst_n(rst_n), .req_a_i(req_a), .req_b_i(req_b),
        .reg_win_i(win), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // {req_a, req_b, mask_a, mask_b, expected irq}
    localparam int NV = 28;
    localparam logic [68:0] VEC [NV] = '{
        {16'h0001, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b01000},
        {16'h0002, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b10000},
        {16'h0004, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00010},
        {16'h0008, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00100},
        {16'h0100, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'h0200, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b10000},
        {16'h0800, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b01000},
        {16'h1000, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00100},
        {16'h0400, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'h80F0, 16'h0000, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'h0000, 16'h0001, 16'hFFFF, 16'hFFFF, 5'b00010},
        {16'h0000, 16'h0002, 16'hFFFF, 16'hFFFF, 5'b01000},
        {16'h0000, 16'h0008, 16'hFFFF, 16'hFFFF, 5'b10000},
        {16'h0000, 16'h0010, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'h0000, 16'h0020, 16'hFFFF, 16'hFFFF, 5'b00100},
        {16'h0000, 16'h0040, 16'hFFFF, 16'hFFFF, 5'b10000},
        {16'h0000, 16'h0080, 16'hFFFF, 16'hFFFF, 5'b01000},
        {16'h0000, 16'h0100, 16'hFFFF, 16'hFFFF, 5'b00100},
        {16'h0000, 16'h0200, 16'hFFFF, 16'hFFFF, 5'b00010},
        {16'h0000, 16'h0400, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'h0000, 16'hF804, 16'hFFFF, 16'hFFFF, 5'b00001},
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 5'b00000},
        {16'hFFFF, 16'h0000, 16'h0002, 16'h0000, 5'b10000},
        {16'h0001, 16'h0002, 16'h0000, 16'hFFFF, 5'b01000},
        {16'h0001, 16'h0002, 16'hFFFF, 16'hFFFF, 5'b01000},
        {16'h0005, 16'h0100, 16'hFFFF, 16'hFFFF, 5'b01110},
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 5'b11111},
        {16'h0008, 16'h0000, 16'hFFF7, 16'hFFFF, 5'b00000}
    };

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic w, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        win = w; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic w, input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        win = w; addr = a;
        #1 d = rdata;
    endtask

    task automatic expect_reg(input logic w, input logic [4:0] a, input logic [15:0] exp,
                              input string req);
        logic [15:0] d;
        bus_read(w, a, d);
        check(d == exp, req, d, exp);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        check(irq == 5'b0, "R1 irq in reset", {11'b0, irq}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(irq == 5'b0, "R1 irq after reset", {11'b0, irq}, 16'h0);
        expect_reg(1'b0, 5'h0C, 16'h0000, "R1 mask A reset");
        expect_reg(1'b1, 5'h06, 16'h0000, "R1 mask B reset");
        expect_reg(1'b0, 5'h04, 16'h0040, "R1 R10 route0 reset");
        expect_reg(1'b0, 5'h06, 16'h0000, "R1 route1 reset");
        expect_reg(1'b0, 5'h1C, 16'h0002, "R1 R10 route2 reset");
        expect_reg(1'b0, 5'h1E, 16'h0000, "R1 route3 reset");

        // R10: default routes with everything enabled
        bus_write(1'b0, 5'h0C, 16'hFFFF);
        bus_write(1'b1, 5'h06, 16'hFFFF);
        expect_reg(1'b0, 5'h0C, 16'hFFFF, "R3 mask A readback");
        expect_reg(1'b1, 5'h06, 16'hFFFF, "R3 mask B readback");
        @(negedge clk); req_a = 16'h0004;
        repeat (2) @(negedge clk);
        check(irq == 5'b00010, "R10 A pin2 default", {11'b0, irq}, 16'h0002);
        @(negedge clk); req_a = 16'h0000; req_b = 16'h0001;
        repeat (2) @(negedge clk);
        check(irq == 5'b00100, "R10 B pin0 default", {11'b0, irq}, 16'h0004);
        @(negedge clk); req_b = 16'h0000; req_a = 16'h0001;
        repeat (2) @(negedge clk);
        check(irq == 5'b00001, "R10 A pin0 default", {11'b0, irq}, 16'h0001);
        @(negedge clk); req_a = 16'h0000;

        // load non-default routes (R5, R6, R7)
        bus_write(1'b0, 5'h04, 16'h0463);
        bus_write(1'b0, 5'h06, 16'h04C4);
        bus_write(1'b0, 5'h1C, 16'h2119);
        bus_write(1'b0, 5'h1E, 16'h029C);
        expect_reg(1'b0, 5'h04, 16'h0463, "R5 route0 readback");
        expect_reg(1'b0, 5'h1E, 16'h029C, "R5 route3 readback");

        // table walk: R2, R6, R7, R9, R12
        for (int v = 0; v < NV; v++) begin
            bus_write(1'b0, 5'h0C, VEC[v][36:21]);
            bus_write(1'b1, 5'h06, VEC[v][20:5]);
            @(negedge clk);
            req_a = VEC[v][68:53];
            req_b = VEC[v][52:37];
            repeat (2) @(negedge clk);
            check(irq == VEC[v][4:0], $sformatf("R2 R6 R7 R9 R12 vector %0d", v),
                  {11'b0, irq}, {11'b0, VEC[v][4:0]});
        end

        // R2: output lags the pending sample by one edge
        bus_write(1'b0, 5'h0C, 16'hFFFF);
        bus_write(1'b1, 5'h06, 16'h0000);
        @(negedge clk); req_a = 16'h0000; req_b = 16'h0000;
        repeat (2) @(negedge clk);
        req_a = 16'h0002;
        @(negedge clk);
        check(irq == 5'b0, "R2 one edge after request", {11'b0, irq}, 16'h0);
        @(negedge clk);
        check(irq == 5'b10000, "R2 two edges after request", {11'b0, irq}, 16'h0010);

        // R4: pending view and ignored writes
        req_a = 16'h1234; req_b = 16'hA5C3;
        @(negedge clk);
        bus_write(1'b0, 5'h00, 16'hFFFF);
        bus_write(1'b1, 5'h00, 16'h0000);
        expect_reg(1'b0, 5'h00, 16'h1234, "R4 pending A");
        expect_reg(1'b1, 5'h00, 16'hA5C3, "R4 pending B");

        // R8: illegal codes keep old value, legal ones in same word stored, bit15 reads 0
        bus_write(1'b0, 5'h04, 16'hD24F);
        expect_reg(1'b0, 5'h04, 16'h024B, "R8 R5 mixed route write");

        // R11: unmapped offsets
        bus_write(1'b1, 5'h0C, 16'h0F0F);
        bus_write(1'b0, 5'h0D, 16'h0F0F);
        bus_write(1'b0, 5'h02, 16'h0F0F);
        bus_write(1'b1, 5'h04, 16'h0000);
        expect_reg(1'b0, 5'h0C, 16'hFFFF, "R11 mask A untouched");
        expect_reg(1'b1, 5'h06, 16'h0000, "R11 mask B untouched");
        expect_reg(1'b0, 5'h04, 16'h024B, "R11 route0 untouched");
        expect_reg(1'b0, 5'h02, 16'h0000, "R11 read A 0x02");
        expect_reg(1'b1, 5'h0C, 16'h0000, "R11 read B 0x0C");
        expect_reg(1'b1, 5'h04, 16'h0000, "R11 read B 0x04");
        bus_read(1'b0, 5'h0D, d);
        check(d == 16'h0000, "R11 read odd offset", d, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule